// File: doc/BRIEF.md
# SD Card Command Line Sequencer

This block issues one SD/MMC command on a single bidirectional command line and, when asked, collects the card's reply. A host pulses `go` while the block is idle. On that cycle it presents a 6-bit command index, a 32-bit argument, four control flags and a reply timeout limit. The block latches all of these values, so the host may change its inputs while the command runs. One bit goes onto the line per clock cycle.

The transaction has up to four phases. It can begin with an optional 80-cycle wake-up run of ones. Next comes the 48-bit command frame, protected by CRC-7. A reply phase follows if one was requested. During that phase the block releases the line and waits a bounded number of cycles for the card's start bit, then shifts in a 48-bit or 136-bit reply. Every transaction ends with a single driven pull-up cycle of 1, during which `done` is high. The reply is checked for CRC and command index when checking is enabled. Its payload lands in four 32-bit reply registers, and three status flags report timeout, CRC mismatch and index mismatch.

Top module: `sdcmd_engine`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `cmd_oe` and all flags are 0, the reply registers are 0. Whenever `cmd_oe` is 0, `cmd_out` is 1.
- R2: `go` is accepted only while `busy` is 0, and the configuration is sampled on that cycle. A `go` pulse while busy, and any change of the configuration inputs after acceptance, have no effect on the running transaction.
- R3: With the init flag set, the cycle after acceptance starts 80 cycles with `cmd_oe`=1 and `cmd_out`=1, before the command frame.
- R4: The command frame is 48 cycles with `cmd_oe`=1, sent MSB first as: 0, 1, index[5:0], argument[31:0], CRC-7 (polynomial x^7+x^3+1, zero start value, over the first 40 bits), 1.
- R5: Without a reply requested, the cycle right after the last frame bit is the pull-up cycle (`cmd_oe`=1, `cmd_out`=1, `done`=1). The block is idle the cycle after.
- R6: With a reply requested, `cmd_oe` is 0 from the cycle after the frame. `cmd_in` is sampled once per cycle, and the first 0 seen is the reply start bit. If the timeout limit is T and T samples pass without a 0, the next cycle is the pull-up cycle with `st_tmo`=1. A 0 on sample T (1-based) is still accepted.
- R7: The long flag selects a 136-bit reply (set) or a 48-bit reply (clear), start bit included. The pull-up cycle with `done`=1 follows the last reply bit directly.
- R8: A 48-bit reply loads reply bits [39:8] into `rsp0` and leaves `rsp1`..`rsp3` unchanged. A 136-bit reply loads reply bits [127:0] into {`rsp3`,`rsp2`,`rsp1`,`rsp0`}. A timeout changes no reply register.
- R9: With checking enabled, `st_crc_err` is set when the reply CRC field (bits [7:1]) differs from CRC-7 over bits [47:8] (short) or bits [127:8] (long). With checking disabled, it stays 0.
- R10: `st_idx_err` is set only for a short reply with checking enabled whose bits [45:40] differ from the command index. Long replies never set it, and the reserved index 6'b111111 they carry is not examined.
- R11: All three flags clear when `go` is accepted and hold their value from the pull-up cycle until the next accepted `go`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start request, taken only when idle |
| cfg_idx | input | 6 | Command index |
| cfg_arg | input | 32 | Command argument |
| cfg_init | input | 1 | Prepend 80 wake-up cycles |
| cfg_resp | input | 1 | A reply is expected |
| cfg_long | input | 1 | Reply is 136 bits instead of 48 |
| cfg_chk | input | 1 | Check reply CRC and index |
| cfg_tmo | input | TMO_W | Reply start-bit limit in cycles |
| cmd_in | input | 1 | Line level seen from the card |
| cmd_out | output | 1 | Line level driven by the block |
| cmd_oe | output | 1 | Line drive enable |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Pull-up cycle that closes a transaction |
| st_tmo | output | 1 | Reply start bit not seen in time |
| st_crc_err | output | 1 | Reply CRC mismatch |
| st_idx_err | output | 1 | Reply index mismatch |
| rsp0 | output | 32 | Reply register 0 |
| rsp1 | output | 32 | Reply register 1 |
| rsp2 | output | 32 | Reply register 2 |
| rsp3 | output | 32 | Reply register 3 |

## Verification
The assertions assume that `cmd_in` is only meaningful while the line is released, and that a timeout limit of at least 1 is programmed. They also assume that `go` may arrive in any cycle, including while busy. The stimulus holds `cmd_in` at 1 whenever the block drives the line and presents the card's bits only in the reply window. It uses limits between 5 and 40 and deliberately raises `go` in the middle of a transaction, with the configuration inputs scrambled after acceptance. Reply delays sit on both sides of the timeout limit, including the last accepted sample.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  localparam int CMD_BITS       = 48;
  localparam int SHORT_RSP_BITS = 48;
  localparam int LONG_RSP_BITS  = 136;
  localparam int SHORT_CRC_HI   = 39;   // last covered bit number, short reply
  localparam int LONG_CRC_LO    = 8;    // first covered bit number, long reply
  localparam int LONG_CRC_HI    = 127;  // last covered bit number, long reply

  typedef enum logic [2:0] {
    ST_IDLE, ST_INIT, ST_TX, ST_WAIT, ST_RX, ST_PUB
  } cmd_st_e;

  // one step of the x^7+x^3+1 shift register
  function automatic logic [6:0] crc7_next(input logic [6:0] c, input logic b);
    logic fb;
    fb = b ^ c[6];
    return {c[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

  function automatic logic [6:0] crc7_of40(input logic [39:0] d);
    logic [6:0] c;
    c = '0;
    for (int i = 39; i >= 0; i--) c = crc7_next(c, d[i]);
    return c;
  endfunction

  function automatic logic [47:0] build_cmd(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] head;
    head = {1'b0, 1'b1, idx, arg};
    return {head, crc7_of40(head), 1'b1};
  endfunction

endpackage

// File: rtl/sdcmd_seq.sv
module sdcmd_seq
  import sdcmd_pkg::*;
#(
  parameter int INIT_CYCLES = 80,
  parameter int TMO_W       = 16,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_acc,
  input  logic             init_sel,
  input  logic             resp_sel,
  input  logic             long_sel,
  input  logic [TMO_W-1:0] tmo_lim,
  input  logic             cmd_in,
  output cmd_st_e          st,
  output logic [CNT_W-1:0] cnt,
  output logic             ev_tx_last,
  output logic             ev_start,
  output logic             ev_tmo,
  output logic             ev_rx_last
);

  localparam logic [CNT_W-1:0] INIT_LAST  = CNT_W'(INIT_CYCLES - 1);
  localparam logic [CNT_W-1:0] TX_LAST    = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_RSP_BITS - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_RSP_BITS - 1);

  logic [TMO_W-1:0] wcnt;
  logic [CNT_W-1:0] rx_last_pos;
  logic [TMO_W:0]   wait_seen;

  assign rx_last_pos = long_sel ? LONG_LAST : SHORT_LAST;
  assign wait_seen   = {1'b0, wcnt} + (TMO_W+1)'(1);

  assign ev_tx_last = (st == ST_TX)   && (cnt == TX_LAST);
  assign ev_start   = (st == ST_WAIT) && !cmd_in;
  assign ev_tmo     = (st == ST_WAIT) && cmd_in && (wait_seen >= {1'b0, tmo_lim});
  assign ev_rx_last = (st == ST_RX)   && (cnt == rx_last_pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      wcnt <= '0;
    end else begin
      case (st)
        ST_IDLE: if (go_acc) begin
          st  <= init_sel ? ST_INIT : ST_TX;
          cnt <= '0;
        end
        ST_INIT: if (cnt == INIT_LAST) begin
          st  <= ST_TX;
          cnt <= '0;
        end else cnt <= cnt + CNT_W'(1);
        ST_TX: if (ev_tx_last) begin
          st   <= resp_sel ? ST_WAIT : ST_PUB;
          cnt  <= '0;
          wcnt <= '0;
        end else cnt <= cnt + CNT_W'(1);
        ST_WAIT: if (ev_start) begin
          st  <= ST_RX;
          cnt <= CNT_W'(1);
        end else if (ev_tmo) st <= ST_PUB;
        else wcnt <= wcnt + TMO_W'(1);
        ST_RX: if (ev_rx_last) st <= ST_PUB;
        else cnt <= cnt + CNT_W'(1);
        ST_PUB:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sdcmd_rsp_rx.sv
module sdcmd_rsp_rx
  import sdcmd_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             shift_en,
  input  logic             bit_in,
  input  logic [CNT_W-1:0] bit_num,
  input  logic             long_sel,
  output logic [127:0]     frame,
  output logic [6:0]       crc_run
);

  localparam logic [CNT_W-1:0] S_HI = CNT_W'(SHORT_CRC_HI);
  localparam logic [CNT_W-1:0] L_LO = CNT_W'(LONG_CRC_LO);
  localparam logic [CNT_W-1:0] L_HI = CNT_W'(LONG_CRC_HI);

  logic [126:0] sh;
  logic         in_rgn;

  // newest bit joins combinationally so the last cycle sees the whole reply
  assign frame  = {sh, bit_in};
  assign in_rgn = long_sel ? ((bit_num >= L_LO) && (bit_num <= L_HI))
                           : (bit_num <= S_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      crc_run <= '0;
    end else if (clr) begin
      sh      <= '0;
      crc_run <= '0;
    end else if (shift_en) begin
      sh <= frame[126:0];
      if (in_rgn) crc_run <= crc7_next(crc_run, bit_in);
    end
  end

endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
  import sdcmd_pkg::*;
#(
  parameter int TMO_W       = 16,
  parameter int INIT_CYCLES = 80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [5:0]       cfg_idx,
  input  logic [31:0]      cfg_arg,
  input  logic             cfg_init,
  input  logic             cfg_resp,
  input  logic             cfg_long,
  input  logic             cfg_chk,
  input  logic [TMO_W-1:0] cfg_tmo,
  input  logic             cmd_in,
  output logic             cmd_out,
  output logic             cmd_oe,
  output logic             busy,
  output logic             done,
  output logic             st_tmo,
  output logic             st_crc_err,
  output logic             st_idx_err,
  output logic [31:0]      rsp0,
  output logic [31:0]      rsp1,
  output logic [31:0]      rsp2,
  output logic [31:0]      rsp3
);

  localparam int MAX_CNT = (INIT_CYCLES > LONG_RSP_BITS) ? INIT_CYCLES : LONG_RSP_BITS;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  cmd_st_e          st;
  logic [CNT_W-1:0] cnt;
  logic             go_acc, ev_tx_last, ev_start, ev_tmo, ev_rx_last, rx_shift;
  logic [5:0]       idx_q;
  logic             resp_q, long_q, chk_q;
  logic [TMO_W-1:0] tmo_q;
  logic [47:0]      tx_sh;
  logic [127:0]     rx_frame;
  logic [6:0]       rx_crc;
  logic             crc_bad, idx_bad;

  assign go_acc   = go && (st == ST_IDLE);
  assign rx_shift = ev_start || (st == ST_RX);
  assign crc_bad  = rx_crc != rx_frame[7:1];
  assign idx_bad  = rx_frame[45:40] != idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      resp_q <= 1'b0;
      long_q <= 1'b0;
      chk_q  <= 1'b0;
      tmo_q  <= '0;
      tx_sh  <= '1;
    end else if (go_acc) begin
      idx_q  <= cfg_idx;
      resp_q <= cfg_resp;
      long_q <= cfg_long;
      chk_q  <= cfg_chk;
      tmo_q  <= cfg_tmo;
      tx_sh  <= build_cmd(cfg_idx, cfg_arg);
    end else if (st == ST_TX) begin
      tx_sh  <= {tx_sh[46:0], 1'b1};
    end
  end

  sdcmd_seq #(.INIT_CYCLES(INIT_CYCLES), .TMO_W(TMO_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .go_acc(go_acc), .init_sel(cfg_init),
    .resp_sel(resp_q), .long_sel(long_q), .tmo_lim(tmo_q), .cmd_in(cmd_in),
    .st(st), .cnt(cnt), .ev_tx_last(ev_tx_last), .ev_start(ev_start),
    .ev_tmo(ev_tmo), .ev_rx_last(ev_rx_last)
  );

  sdcmd_rsp_rx #(.CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(ev_tx_last), .shift_en(rx_shift),
    .bit_in(cmd_in), .bit_num(cnt), .long_sel(long_q),
    .frame(rx_frame), .crc_run(rx_crc)
  );

  always_comb begin
    cmd_oe  = 1'b0;
    cmd_out = 1'b1;
    case (st)
      ST_INIT: cmd_oe = 1'b1;
      ST_TX: begin
        cmd_oe  = 1'b1;
        cmd_out = tx_sh[47];
      end
      ST_PUB:  cmd_oe = 1'b1;
      default: cmd_oe = 1'b0;
    endcase
  end

  assign busy = st != ST_IDLE;
  assign done = st == ST_PUB;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_tmo     <= 1'b0;
      st_crc_err <= 1'b0;
      st_idx_err <= 1'b0;
      rsp0 <= '0;
      rsp1 <= '0;
      rsp2 <= '0;
      rsp3 <= '0;
    end else if (go_acc) begin
      st_tmo     <= 1'b0;
      st_crc_err <= 1'b0;
      st_idx_err <= 1'b0;
    end else begin
      if (ev_tmo) st_tmo <= 1'b1;
      if (ev_rx_last) begin
        st_crc_err <= chk_q && crc_bad;
        st_idx_err <= chk_q && !long_q && idx_bad;
        if (long_q) {rsp3, rsp2, rsp1, rsp0} <= rx_frame;
        else        rsp0 <= rx_frame[39:8];
      end
    end
  end

endmodule

// File: rtl/sdcmd_chk.sv
module sdcmd_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        go,
  input logic        busy,
  input logic        cmd_oe,
  input logic        cmd_out,
  input logic        done,
  input logic        st_tmo,
  input logic [31:0] rsp0,
  input logic        ev_start,
  input logic        ev_tmo,
  input logic        ev_rx_last
);

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_oe |-> cmd_out);  // R1
  AST_GO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !busy) |=> busy);  // R2
  AST_PULLUP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cmd_oe && cmd_out && busy));  // R5
  AST_TMO_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tmo |=> (done && st_tmo));  // R6
  AST_LINE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |-> !cmd_oe);  // R6
  AST_RX_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_last |=> done);  // R7
  AST_DONE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));  // R7
  AST_RSP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rsp0) |-> done);  // R8

endmodule

bind sdcmd_engine sdcmd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .cmd_oe(cmd_oe),
  .cmd_out(cmd_out), .done(done), .st_tmo(st_tmo), .rsp0(rsp0),
  .ev_start(ev_start), .ev_tmo(ev_tmo), .ev_rx_last(ev_rx_last)
);

// File: tb/sim_sdcmd_engine.sv
module sim_sdcmd_engine;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, go, cfg_init, cfg_resp, cfg_long, cfg_chk, cmd_in;
  logic [5:0]  cfg_idx;
  logic [31:0] cfg_arg;
  logic [15:0] cfg_tmo;
  logic        cmd_out, cmd_oe, busy, done, st_tmo, st_crc_err, st_idx_err;
  logic [31:0] rsp0, rsp1, rsp2, rsp3;

  sdcmd_engine u0 (
    .clk(clk), .rst_n(rst_n), .go(go), .cfg_idx(cfg_idx), .cfg_arg(cfg_arg),
    .cfg_init(cfg_init), .cfg_resp(cfg_resp), .cfg_long(cfg_long),
    .cfg_chk(cfg_chk), .cfg_tmo(cfg_tmo), .cmd_in(cmd_in), .cmd_out(cmd_out),
    .cmd_oe(cmd_oe), .busy(busy), .done(done), .st_tmo(st_tmo),
    .st_crc_err(st_crc_err), .st_idx_err(st_idx_err),
    .rsp0(rsp0), .rsp1(rsp1), .rsp2(rsp2), .rsp3(rsp3)
  );

  int checks = 0;
  int errors = 0;
  logic [127:0] m_rsp;
  logic m_tmo, m_crc, m_idx;

  task automatic check(input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // remainder of the message followed by seven zeros, modulo 0x89
  function automatic logic [6:0] ref_crc(input logic [119:0] m, input int n);
    logic [7:0] r;
    r = '0;
    for (int k = n + 6; k >= 0; k--) begin
      r = {r[6:0], (k >= 7) ? m[k-7] : 1'b0};
      if (r[7]) r = r ^ 8'h89;
    end
    return r[6:0];
  endfunction

  task automatic check_idle(input string tag);
    check(tag, "idle busy/oe/out/done", {busy, cmd_oe, cmd_out, done}, 4'b0010);
    check("R11", "flags held", {st_tmo, st_crc_err, st_idx_err}, {m_tmo, m_crc, m_idx});
    check("R8", "regs held", {rsp3, rsp2, rsp1, rsp0}, m_rsp);
  endtask

  task automatic run(input bit init, input logic [5:0] idx, input logic [31:0] arg,
                     input bit resp, input bit lng, input bit chk, input int tmo,
                     input int dly, input bit bad_crc, input bit bad_idx, input bit poke);
    logic [3:0]   eq[$];
    logic         cq[$];
    string        tq[$];
    logic [47:0]  cf;
    logic [135:0] rf;
    logic [39:0]  b40;
    logic [119:0] b120;
    logic [6:0]   c;
    bit           to;
    int           len;
    cf = {2'b01, idx, arg, ref_crc({80'b0, 2'b01, idx, arg}, 40), 1'b1};
    if (init) for (int i = 0; i < 80; i++) begin eq.push_back(4'b1110); cq.push_back(1'b1); tq.push_back("R3"); end
    for (int i = 0; i < 48; i++) begin eq.push_back({2'b11, cf[47-i], 1'b0}); cq.push_back(1'b1); tq.push_back("R4"); end
    to = 1'b0;
    rf = '0;
    if (resp) begin
      len = lng ? 136 : 48;
      if (lng) begin
        b120 = {arg, ~arg, arg ^ 32'hdead0001, 24'h5c3a71};
        c = ref_crc(b120, 120);
        if (bad_crc) c = c ^ 7'h10;
        rf = {2'b00, 6'h3f, b120, c, 1'b1};
      end else begin
        b40 = {2'b00, bad_idx ? ~idx : idx, arg ^ 32'h5a5a1234};
        c = ref_crc({80'b0, b40}, 40);
        if (bad_crc) c = c ^ 7'h10;
        rf = {88'b0, b40, c, 1'b1};
      end
      if (dly >= tmo) begin
        to = 1'b1;
        for (int i = 0; i < tmo; i++) begin eq.push_back(4'b1010); cq.push_back(1'b1); tq.push_back("R6"); end
      end else begin
        for (int i = 0; i < dly; i++) begin eq.push_back(4'b1010); cq.push_back(1'b1); tq.push_back("R6"); end
        for (int k = 0; k < len; k++) begin eq.push_back(4'b1010); cq.push_back(rf[len-1-k]); tq.push_back("R7"); end
      end
    end
    eq.push_back(4'b1111); cq.push_back(1'b1); tq.push_back(resp ? "R7" : "R5");
    m_tmo = to;
    m_crc = resp && !to && chk && bad_crc;
    m_idx = resp && !to && chk && !lng && bad_idx;
    if (resp && !to) begin
      if (lng) m_rsp = rf[127:0];
      else     m_rsp[31:0] = rf[39:8];
    end
    @(negedge clk);
    check("R1", "idle before go", {busy, cmd_oe, cmd_out, done}, 4'b0010);
    cfg_init = init; cfg_idx = idx; cfg_arg = arg; cfg_resp = resp;
    cfg_long = lng; cfg_chk = chk; cfg_tmo = 16'(tmo); go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    // R2: scramble configuration once the command is taken
    cfg_init = ~init; cfg_idx = ~idx; cfg_arg = ~arg; cfg_resp = ~resp;
    cfg_long = ~lng; cfg_chk = ~chk; cfg_tmo = 16'd1;
    for (int n = 0; n < eq.size(); n++) begin
      cmd_in = cq[n];
      go = poke && (n == 3);  // R2: request while busy
      check(tq[n], "busy/oe/out/done", {busy, cmd_oe, cmd_out, done}, eq[n]);
      if (eq[n][0]) begin
        check("R6", "timeout flag", st_tmo, m_tmo);
        check("R9", "crc flag", st_crc_err, m_crc);
        check("R10", "index flag", st_idx_err, m_idx);
        check("R8", "reply regs", {rsp3, rsp2, rsp1, rsp0}, m_rsp);
      end
      @(negedge clk);
    end
    go = 1'b0;
    cmd_in = 1'b1;
    check_idle("R5");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; go = 1'b0; cmd_in = 1'b1; cfg_init = 1'b0; cfg_idx = '0;
    cfg_arg = '0; cfg_resp = 1'b0; cfg_long = 1'b0; cfg_chk = 1'b0; cfg_tmo = 16'd8;
    m_rsp = '0; m_tmo = 1'b0; m_crc = 1'b0; m_idx = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "reset outputs", {busy, cmd_oe, cmd_out, done, st_tmo, st_crc_err, st_idx_err}, 7'b0010000);
    check("R1", "reset regs", {rsp3, rsp2, rsp1, rsp0}, '0);
    //  init idx    arg            rsp lng chk tmo dly bcrc bidx poke
    run(0, 6'd0,  32'h00000000, 0, 0, 0, 8,  0, 0, 0, 0);  // R4 R5
    run(1, 6'd8,  32'h000001aa, 0, 0, 0, 8,  0, 0, 0, 1);  // R3 R2
    run(0, 6'd17, 32'h12345678, 1, 0, 1, 20, 2, 0, 0, 0);  // R6 R7 R8
    run(0, 6'd17, 32'h0badcafe, 1, 0, 1, 20, 1, 1, 0, 0);  // R9
    run(0, 6'd55, 32'hffff0000, 1, 0, 1, 20, 0, 0, 1, 0);  // R10 R11
    run(0, 6'd55, 32'h13579bdf, 1, 0, 0, 20, 3, 1, 1, 0);  // R9 R10 unchecked
    run(0, 6'd2,  32'hcafef00d, 1, 1, 1, 40, 0, 0, 0, 1);  // R7 R8 long
    run(0, 6'd9,  32'h76543210, 1, 1, 1, 40, 5, 1, 0, 0);  // R9 long
    run(0, 6'd13, 32'h00c0ffee, 1, 0, 1, 5,  10, 0, 0, 0); // R6 timeout
    run(0, 6'd13, 32'h11111111, 1, 0, 1, 5,  4, 0, 0, 0);  // R6 last sample
    run(0, 6'd13, 32'h22222222, 1, 0, 1, 5,  5, 0, 0, 0);  // R6 one late
    run(1, 6'd41, 32'h89abcdef, 1, 0, 1, 30, 7, 0, 0, 1);  // R8 short after long
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule